// File: doc/BRIEF.md
# Debug Port Serial Shift Interface

This block is the serial link between an external debug tool and a processor core. The tool supplies a shift strobe and a data-in line. The port answers on a data-out line in full duplex. Every transfer is a 35-bit frame. While the core is halted in debug mode, the port paces the tool: the idle level of the data-out line says whether the core is currently waiting for an instruction or a data word. Each outgoing frame carries a two-bit status code and a 32-bit field. The field is either a word the core wrote or all ones.

On the core side there are three parts. Read requests for an instruction or a data word are single-cycle pulses. A write pulse hands over a word to be shifted out. The received words come back on separate valid strobes. A frame whose mode bit is set carries a 7-bit control command instead of a word. A frame that breaks the pacing rules is discarded as a no-operation and flagged in the status of the following frame.

The shift strobe is a one-cycle enable in the block's own clock domain; synchronising a raw tool clock is done outside.

Top module: `dbg_serial_port`

## Requirements
- R1: A frame starts with a strobe on which the serial input is 1 while the port is idle. It is followed by 34 strobes carrying the mode bit, the control bit and a 32-bit word, most significant bit first.
- R2: In debug mode, the idle serial output is low (ready) exactly when an instruction read or a data read is pending. Otherwise it is high.
- R3: A core write does not drive the idle output low. The written word is sent after the start strobe: first the status bit pair (first bit after the start strobe, second after the next), then the 32-bit field most significant bit first.
- R4: The status code, first bit then second, is 00 for valid core data, 01 for a sequencing error, 10 for a core interrupt and 11 for null.
- R5: For the codes 01, 10 and 11, the outgoing 32-bit field is all ones.
- R6: A start strobe in debug mode with no read pending is a sequencing error. That frame produces no word and no command, and the next frame reports code 01.
- R7: Outside debug mode, the idle output is always low. A frame with mode bit 0 is a sequencing error: it is ignored and reported as 01 in the next frame.
- R8: While trap enable is high, codes 00 and 10 are never sent, and a pending written word stays pending.
- R9: A frame with mode bit 1 produces a one-cycle command strobe. The 7-bit command is the control bit followed by the six most significant data bits. A pending read is not consumed by it.
- R10: A valid frame with mode bit 0 delivers its word on the instruction strobe if an instruction read is pending, otherwise on the data strobe. The delivery clears that pending read. At most one output strobe fires per cycle.
- R11: After reset, the serial output is high, all output strobes are low and nothing is pending.
- R12: Status priority is sequencing error, then valid data, then interrupt, then null.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_mode | input | 1 | Core is halted in debug mode |
| trap_en | input | 1 | Trap enable; suppresses valid-data and interrupt codes |
| core_irq | input | 1 | Core interrupt pending |
| rd_instr_req | input | 1 | Pulse: core wants an instruction word |
| rd_data_req | input | 1 | Pulse: core wants a data word |
| wr_valid | input | 1 | Pulse: core writes a word for the tool |
| wr_word | input | 32 | Word written by the core |
| shift_en | input | 1 | One-cycle shift strobe from the tool |
| sdi | input | 1 | Serial data from the tool |
| sdo | output | 1 | Serial data / ready level to the tool |
| instr_valid | output | 1 | Received word is an instruction |
| data_valid | output | 1 | Received word is data |
| rx_word | output | 32 | Received 32-bit word |
| cmd_valid | output | 1 | Control command received |
| cmd | output | 7 | Received control command |

## Verification
The bench targets these corner cases:
- A start strobe with no read pending. A design that missed it would hand a stray word to the core, or keep reporting null where code 01 belongs.
- A core write followed by a read request. A design that raised ready on the write would pull the idle line low too early.
- Trap enable with both a written word and an interrupt pending. A wrong design would leak code 00 or 10, or throw away the word.
- A command frame, which must leave the pending read untouched.
- Mode-0 frames outside debug mode, which must be flagged.

Random frames check bit order, the all-ones field and instruction-versus-data routing.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  typedef enum logic [1:0] {
    ST_VALID  = 2'b00,
    ST_SEQERR = 2'b01,
    ST_IRQ    = 2'b10,
    ST_NULL   = 2'b11
  } dbgp_status_e;
endpackage

// File: rtl/dbgp_rx_shift.sv
module dbgp_rx_shift #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              sdi,
  output logic              start_o,
  output logic              end_o,
  output logic              busy_o,
  output logic              mode_o,
  output logic              ctrl_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int FRAME_LEN = DATA_W + 3;
  localparam int BODY_W    = DATA_W + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [BODY_W-2:0] body_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic [BODY_W-1:0] full;

  assign full    = {body_q, sdi};
  assign start_o = shift_en & ~busy_q & sdi;
  assign end_o   = shift_en & busy_q & (cnt_q == LAST);
  assign busy_o  = busy_q;
  assign mode_o  = full[BODY_W-1];
  assign ctrl_o  = full[BODY_W-2];
  assign data_o  = full[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      body_q <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
    end else if (shift_en && busy_q) begin
      body_q <= full[BODY_W-2:0];
      cnt_q  <= cnt_q + CNT_W'(1);
      if (end_o) busy_q <= 1'b0;
    end
  end

  // R1: the bit counter stays inside one frame
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q >= CNT_W'(1) && cnt_q <= LAST));
  // R1: a completed frame returns the receiver to idle
  p_end_idle_r1: assert property (@(posedge clk) disable iff (rst)
    end_o |=> !busy_q);
endmodule

// File: rtl/dbgp_tx_shift.sv
module dbgp_tx_shift
  import dbgp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  dbgp_status_e      code_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              shift_i,
  input  logic              finish_i,
  input  logic              busy_i,
  input  logic              idle_level_i,
  output logic              sdo_o
);
  logic [DATA_W:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_o <= 1'b1;
      sh_q  <= '1;
    end else if (load_i) begin
      sdo_o <= code_i[1];
      sh_q  <= {code_i[0], word_i};
    end else if (shift_i) begin
      sdo_o <= sh_q[DATA_W];
      sh_q  <= {sh_q[DATA_W-1:0], 1'b1};
    end else if (finish_i) begin
      sdo_o <= 1'b1;
    end else if (!busy_i) begin
      sdo_o <= idle_level_i;
    end
  end

  // R5: any non-valid code comes with an all-ones field
  p_ones_field_r5: assert property (@(posedge clk) disable iff (rst)
    (load_i && code_i != ST_VALID) |-> (word_i == '1));
endmodule

// File: rtl/dbgp_core_side.sv
module dbgp_core_side
  import dbgp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CMD_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_mode,
  input  logic              trap_en,
  input  logic              core_irq,
  input  logic              rd_instr_req,
  input  logic              rd_data_req,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              mode_i,
  input  logic              ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  output dbgp_status_e      code_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              idle_level_o,
  output logic              instr_valid,
  output logic              data_valid,
  output logic [DATA_W-1:0] rx_word,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd
);
  logic              pend_ir_q, pend_dr_q, wr_pend_q, seq_pend_q, frame_err_q;
  logic [DATA_W-1:0] wr_buf_q;
  logic              ready;
  logic              bad_frame;

  assign ready        = ~dbg_mode | pend_ir_q | pend_dr_q;
  assign idle_level_o = ~ready;
  assign bad_frame    = frame_err_q | (~dbg_mode & ~mode_i);

  always_comb begin
    if (seq_pend_q)                 code_o = ST_SEQERR;
    else if (wr_pend_q && !trap_en) code_o = ST_VALID;
    else if (core_irq && !trap_en)  code_o = ST_IRQ;
    else                            code_o = ST_NULL;
    tx_word_o = (code_o == ST_VALID) ? wr_buf_q : '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_ir_q   <= 1'b0;
      pend_dr_q   <= 1'b0;
      wr_pend_q   <= 1'b0;
      seq_pend_q  <= 1'b0;
      frame_err_q <= 1'b0;
      wr_buf_q    <= '0;
      instr_valid <= 1'b0;
      data_valid  <= 1'b0;
      cmd_valid   <= 1'b0;
      rx_word     <= '0;
      cmd         <= '0;
    end else begin
      instr_valid <= 1'b0;
      data_valid  <= 1'b0;
      cmd_valid   <= 1'b0;
      if (start_i) begin
        frame_err_q <= dbg_mode & ~pend_ir_q & ~pend_dr_q;
        if (code_o == ST_SEQERR) seq_pend_q <= 1'b0;
        if (code_o == ST_VALID)  wr_pend_q  <= 1'b0;
      end
      if (end_i) begin
        if (bad_frame) begin
          seq_pend_q <= 1'b1;
        end else if (mode_i) begin
          cmd_valid <= 1'b1;
          cmd       <= {ctrl_i, data_i[DATA_W-1 -: CMD_W-1]};
        end else if (pend_ir_q) begin
          instr_valid <= 1'b1;
          rx_word     <= data_i;
          pend_ir_q   <= 1'b0;
        end else if (pend_dr_q) begin
          data_valid <= 1'b1;
          rx_word    <= data_i;
          pend_dr_q  <= 1'b0;
        end
      end
      if (rd_instr_req) pend_ir_q <= 1'b1;
      if (rd_data_req)  pend_dr_q <= 1'b1;
      if (wr_valid) begin
        wr_pend_q <= 1'b1;
        wr_buf_q  <= wr_word;
      end
    end
  end

  // R10: never more than one output strobe per cycle
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({instr_valid, data_valid, cmd_valid}));
  // R6: a flagged frame yields nothing on the core side
  p_nop_frame_r6: assert property (@(posedge clk) disable iff (rst)
    (end_i && frame_err_q) |=> !(instr_valid || data_valid || cmd_valid));
  // R6: a flagged frame is reported in the following status
  p_seq_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (end_i && frame_err_q) |=> seq_pend_q);
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
  import dbgp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CMD_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_mode,
  input  logic              trap_en,
  input  logic              core_irq,
  input  logic              rd_instr_req,
  input  logic              rd_data_req,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              shift_en,
  input  logic              sdi,
  output logic              sdo,
  output logic              instr_valid,
  output logic              data_valid,
  output logic [DATA_W-1:0] rx_word,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd
);
  logic              start_w, end_w, busy_w, mode_w, ctrl_w, idle_w;
  logic [DATA_W-1:0] data_w, txw_w;
  dbgp_status_e      code_w;

  dbgp_rx_shift #(.DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(sdi),
    .start_o(start_w), .end_o(end_w), .busy_o(busy_w),
    .mode_o(mode_w), .ctrl_o(ctrl_w), .data_o(data_w)
  );

  dbgp_core_side #(.DATA_W(DATA_W), .CMD_W(CMD_W)) core_i (
    .clk(clk), .rst(rst), .dbg_mode(dbg_mode), .trap_en(trap_en),
    .core_irq(core_irq), .rd_instr_req(rd_instr_req), .rd_data_req(rd_data_req),
    .wr_valid(wr_valid), .wr_word(wr_word), .start_i(start_w), .end_i(end_w),
    .mode_i(mode_w), .ctrl_i(ctrl_w), .data_i(data_w), .code_o(code_w),
    .tx_word_o(txw_w), .idle_level_o(idle_w), .instr_valid(instr_valid),
    .data_valid(data_valid), .rx_word(rx_word), .cmd_valid(cmd_valid), .cmd(cmd)
  );

  dbgp_tx_shift #(.DATA_W(DATA_W)) tx_i (
    .clk(clk), .rst(rst), .load_i(start_w), .code_i(code_w), .word_i(txw_w),
    .shift_i(shift_en & busy_w & ~end_w), .finish_i(end_w), .busy_i(busy_w),
    .idle_level_i(idle_w), .sdo_o(sdo)
  );

  // R8: trap enable keeps valid-data and interrupt codes off the line
  p_trap_codes_r8: assert property (@(posedge clk) disable iff (rst)
    (start_w && trap_en) |-> (code_w == ST_SEQERR || code_w == ST_NULL));
  // R7: outside debug mode the idle line shows ready
  p_ready_nodbg_r7: assert property (@(posedge clk) disable iff (rst)
    (!dbg_mode && !busy_w) |-> !idle_w);
endmodule

// File: tb/dbg_serial_port_tb_top.sv
module dbg_serial_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_mode = 1'b1, trap_en = 1'b0, core_irq = 1'b0;
  logic        rd_instr_req = 1'b0, rd_data_req = 1'b0, wr_valid = 1'b0;
  logic [31:0] wr_word = '0;
  logic        shift_en = 1'b0, sdi = 1'b0;
  logic        sdo, instr_valid, data_valid, cmd_valid;
  logic [31:0] rx_word;
  logic [6:0]  cmd;

  int checks = 0, failures = 0;
  int n_instr = 0, n_data = 0, n_cmd = 0;
  logic [31:0] got_instr, got_data;
  logic [6:0]  got_cmd;

  always #2.5 clk = ~clk;

  dbg_serial_port dut_i (
    .clk(clk), .rst(rst), .dbg_mode(dbg_mode), .trap_en(trap_en), .core_irq(core_irq),
    .rd_instr_req(rd_instr_req), .rd_data_req(rd_data_req), .wr_valid(wr_valid),
    .wr_word(wr_word), .shift_en(shift_en), .sdi(sdi), .sdo(sdo),
    .instr_valid(instr_valid), .data_valid(data_valid), .rx_word(rx_word),
    .cmd_valid(cmd_valid), .cmd(cmd)
  );

  always @(negedge clk) begin
    if (instr_valid) begin n_instr++; got_instr = rx_word; end
    if (data_valid)  begin n_data++;  got_data  = rx_word; end
    if (cmd_valid)   begin n_cmd++;   got_cmd   = cmd;     end
  end

  task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic strobe(input logic b, output logic so);
    @(negedge clk); shift_en = 1'b1; sdi = b;
    @(negedge clk); shift_en = 1'b0; sdi = 1'b0;
    @(negedge clk); so = sdo;
  endtask

  task automatic frame(input logic mode, input logic ctrl, input logic [31:0] d,
                       output logic [1:0] code, output logic [31:0] w);
    logic s;
    strobe(1'b1, s); code[1] = s;
    strobe(mode, s); code[0] = s;
    strobe(ctrl, s); w[31] = s;
    for (int i = 31; i >= 1; i--) begin
      strobe(d[i], s); w[i-1] = s;
    end
    strobe(d[0], s);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_instr(); @(negedge clk); rd_instr_req = 1; @(negedge clk); rd_instr_req = 0; repeat (2) @(negedge clk); endtask
  task automatic pulse_data();  @(negedge clk); rd_data_req = 1;  @(negedge clk); rd_data_req = 0;  repeat (2) @(negedge clk); endtask
  task automatic write_word(input logic [31:0] w);
    @(negedge clk); wr_valid = 1; wr_word = w; @(negedge clk); wr_valid = 0; repeat (2) @(negedge clk);
  endtask

  function automatic logic [6:0] exp_cmd(input logic c, input logic [31:0] d);
    return {c, d[31:26]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [1:0]  c;
    logic [31:0] w, d;
    int          ni, nd, nc;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 sdo", sdo, 1);
    check("R11 strobes", {instr_valid, data_valid, cmd_valid}, 0);

    // R7 outside debug: ready low, mode-0 frame flagged
    dbg_mode = 0; repeat (3) @(negedge clk);
    check("R7 idle ready", sdo, 0);
    ni = n_instr; nd = n_data;
    frame(0, 0, 32'h1234_5678, c, w);
    check("R7 ignored", {n_instr - ni, n_data - nd}, 0);
    check("R7 ready after", sdo, 0);
    d = 32'hA5C0_0000; nc = n_cmd;
    frame(1, 1, d, c, w);
    check("R7 seq code", c, 2'b01);
    check("R9 cmd out of debug", {n_cmd - nc, got_cmd}, {32'd1, exp_cmd(1, d)});
    frame(1, 0, d, c, w);
    check("R4 null", {c, w}, {2'b11, 32'hFFFF_FFFF});

    // R2 / R3 / R10 debug pacing
    dbg_mode = 1; repeat (3) @(negedge clk);
    check("R2 not ready", sdo, 1);
    write_word(32'hCAFE_0001);
    check("R3 write no ready", sdo, 1);
    pulse_instr();
    check("R2 ready", sdo, 0);
    ni = n_instr;
    frame(0, 0, 32'h0BAD_F00D, c, w);
    check("R3 valid word", {c, w}, {2'b00, 32'hCAFE_0001});
    check("R10 instr", {n_instr - ni, got_instr}, {32'd1, 32'h0BAD_F00D});
    check("R10 cleared", sdo, 1);

    // R6 sequencing error in debug
    ni = n_instr; nd = n_data; nc = n_cmd;
    frame(1, 1, 32'hFFFF_FFFF, c, w);
    check("R6 nop", {n_instr - ni, n_data - nd, n_cmd - nc}, 0);
    pulse_instr();
    frame(0, 0, 32'h1111_2222, c, w);
    check("R6 code", {c, w}, {2'b01, 32'hFFFF_FFFF});
    check("R6 recover", got_instr, 32'h1111_2222);

    // R8 trap enable
    trap_en = 1; core_irq = 1;
    write_word(32'h7777_8888);
    pulse_data();
    nd = n_data;
    frame(0, 0, 32'h0000_0042, c, w);
    check("R8 trap null", {c, w}, {2'b11, 32'hFFFF_FFFF});
    check("R10 data", {n_data - nd, got_data}, {32'd1, 32'h0000_0042});
    trap_en = 0;
    pulse_data();
    frame(0, 0, 32'h0000_0043, c, w);
    check("R8 word kept", {c, w}, {2'b00, 32'h7777_8888});
    pulse_data();
    frame(0, 0, 32'h0000_0044, c, w);
    check("R4 irq", {c, w}, {2'b10, 32'hFFFF_FFFF});
    core_irq = 0;

    // R12 priority: pending seq error beats a pending write
    frame(0, 0, 0, c, w);
    write_word(32'h5555_AAAA);
    core_irq = 1;
    pulse_instr();
    frame(0, 0, 1, c, w);
    check("R12 seq first", c, 2'b01);
    pulse_instr();
    frame(0, 0, 2, c, w);
    check("R12 valid next", {c, w}, {2'b00, 32'h5555_AAAA});
    core_irq = 0;

    // random mix
    for (int it = 0; it < 30; it++) begin
      int sel;
      logic irq_b, cb;
      sel = $urandom % 3; d = $urandom; irq_b = $urandom; cb = $urandom;
      if (sel == 0) begin
        core_irq = irq_b; pulse_instr(); ni = n_instr;
        frame(0, cb, d, c, w);
        check("R1 rand instr", {n_instr - ni, got_instr}, {32'd1, d});
        check("R5 rand code", {c, w}, {irq_b ? 2'b10 : 2'b11, 32'hFFFF_FFFF});
        core_irq = 0;
      end else if (sel == 1) begin
        logic [31:0] wv;
        wv = $urandom;
        write_word(wv); pulse_data(); nd = n_data;
        frame(0, cb, d, c, w);
        check("R3 rand word", {c, w}, {2'b00, wv});
        check("R10 rand data", {n_data - nd, got_data}, {32'd1, d});
      end else begin
        pulse_instr(); nc = n_cmd;
        frame(1, cb, d, c, w);
        check("R9 rand cmd", {n_cmd - nc, got_cmd}, {32'd1, exp_cmd(cb, d)});
        check("R9 still ready", sdo, 0);
        ni = n_instr;
        frame(0, 0, d, c, w);
        check("R1 after cmd", {n_instr - ni, got_instr}, {32'd1, d});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule